// File: doc/BRIEF.md
# ADC Result Register Front-End

This block sits between a 10-bit analog-to-digital converter core and a byte-wide register bus. The core is reduced here to a one-cycle `conv_done` strobe that carries a finished result. The block keeps the most recent result and shows it as two read-only bytes: a low byte at 0x78 and a high byte at 0x79. An input selects how the result is placed across the two bytes. It can be packed against bit 0 (right-aligned) or against bit 15 (left-aligned).

Software reads the low byte first and the high byte second to get a full result that belongs to one conversion. Reading the low byte locks the visible result. A conversion that finishes while the result is locked goes into a shadow register, and it moves to the visible register when the high byte is read. When the result is left-aligned, a single read of the high byte gives an 8-bit value and takes no lock.

A control byte at 0x7B holds a 3-bit field that picks one of several interrupt-flag inputs as the auto-trigger source. While `auto_trig_en` is high, a rising edge on the selected flag produces a single-cycle `conv_start` pulse. A change of selection from a low flag to a high flag also counts as a rising edge.

Top module: `adc_result_front`

## Requirements
- R1: After reset, the low byte, the high byte and the control byte all read 0x00, and `conv_start` is low.
- R2: With `left_align` low, the high byte reads {6'b0, result[9:8]} and the low byte reads result[7:0]. Read data appears on `bus_rdata` in the cycle after the read strobe.
- R3: With `left_align` high, the high byte reads result[9:2] and the low byte reads {result[1:0], 6'b0}.
- R4: A read of the low byte (0x78) locks the result. Results that complete after that read leave both data bytes unchanged until the high byte (0x79) is read.
- R5: A result that completes while the registers are locked is held in a shadow register and becomes visible when the high byte is read. Only the latest of several such results is kept.
- R6: A read of the high byte without a prior low-byte read takes no lock, so a later conversion updates the result at once.
- R7: Bits 2:0 and bit 6 of the control byte (0x7B) are written when `bus_wr` is high. Bits 7 and 5:3 always read zero.
- R8: While `auto_trig_en` is low, no `conv_start` pulse is produced, whatever the flags do.
- R9: While `auto_trig_en` is high, a 0-to-1 change of the selected flag (index = control bits 2:0) gives exactly one `conv_start` pulse, one cycle wide. A flag that stays high gives no further pulses.
- R10: Changing the selected source from one whose flag is low to one whose flag is high produces one `conv_start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| left_align | input | 1 | 1 places the result against bit 15 of the byte pair |
| auto_trig_en | input | 1 | Enables starts from the selected flag |
| trig_flags | input | SRC_N | Interrupt-flag inputs, one per trigger source |
| conv_done | input | 1 | One-cycle strobe: a result is ready |
| conv_result | input | RES_W | Result that comes with `conv_done` |
| conv_start | output | 1 | One-cycle conversion request |

## Verification
The bench uses the defaults: `RES_W` = 10 and `SRC_N` = 8. With these values every 3-bit trigger code names a real flag, so any pair of sources can be used for the selection-change edge. The 10-bit width makes both byte layouts fully visible, including the zero fill in the high byte and in the low byte. The lock tests send two conversions during one locked window, which shows that the shadow register keeps only the last result.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;
  localparam logic [7:0] ADDR_LO   = 8'h78;
  localparam logic [7:0] ADDR_HI   = 8'h79;
  localparam logic [7:0] ADDR_CTRL = 8'h7B;
  // writable bits of the control byte: 6 and 2:0
  localparam logic [7:0] CTRL_WMASK = 8'h47;
  localparam int unsigned SEL_W = 3;
endpackage

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  input  logic             rd_lo,
  input  logic             rd_hi,
  output logic [RES_W-1:0] data_q,
  output logic             locked_q
);
  logic [RES_W-1:0] shadow_q;
  logic             pend_q;
  logic             hold_now;

  // a result that lands in the same cycle as the low read is deferred too
  assign hold_now = (locked_q | rd_lo) & ~rd_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      shadow_q <= '0;
      pend_q   <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      if (rd_hi) begin
        locked_q <= 1'b0;
        if (conv_done)   data_q <= conv_result;
        else if (pend_q) data_q <= shadow_q;
        pend_q <= 1'b0;
      end else if (hold_now) begin
        locked_q <= 1'b1;
        if (conv_done) begin
          shadow_q <= conv_result;
          pend_q   <= 1'b1;
        end
      end else if (conv_done) begin
        data_q <= conv_result;
      end
    end
  end
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int unsigned SRC_N = 8,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [SEL_W-1:0] sel,
  input  logic [SRC_N-1:0] flags,
  output logic             start_q
);
  localparam int unsigned FULL_N = 1 << SEL_W;
  logic [FULL_N-1:0] flags_full;
  logic              sel_flag;
  logic              prev_q;

  generate
    if (SRC_N < FULL_N) begin : g_pad
      assign flags_full = {{(FULL_N-SRC_N){1'b0}}, flags};
    end else begin : g_full
      assign flags_full = flags[FULL_N-1:0];
    end
  endgenerate

  assign sel_flag = flags_full[sel];

  // prev_q follows whichever flag is selected, so a selection change acts as an edge
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      prev_q  <= sel_flag;
      start_q <= enable & sel_flag & ~prev_q;
    end
  end
endmodule

// File: rtl/adc_bus_regs.sv
module adc_bus_regs
  import adc_fe_pkg::*;
#(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  input  logic             left_align,
  input  logic [RES_W-1:0] data,
  output logic [7:0]       rdata_q,
  output logic [SEL_W-1:0] trig_sel,
  output logic             rd_lo,
  output logic             rd_hi
);
  logic [7:0]  ctrl_q;
  logic [15:0] placed;
  logic [7:0]  rd_mux;

  assign rd_lo    = bus_rd & (bus_addr == ADDR_LO);
  assign rd_hi    = bus_rd & (bus_addr == ADDR_HI);
  assign trig_sel = ctrl_q[SEL_W-1:0];
  assign placed   = left_align ? (16'(data) << (16 - RES_W)) : 16'(data);

  always_comb begin
    case (bus_addr)
      ADDR_LO:   rd_mux = placed[7:0];
      ADDR_HI:   rd_mux = placed[15:8];
      ADDR_CTRL: rd_mux = ctrl_q;
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= 8'h00;
      rdata_q <= 8'h00;
    end else begin
      if (bus_wr && bus_addr == ADDR_CTRL) ctrl_q <= bus_wdata & CTRL_WMASK;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end
endmodule

// File: rtl/adc_result_front.sv
module adc_result_front
  import adc_fe_pkg::*;
#(
  parameter int unsigned RES_W = 10,
  parameter int unsigned SRC_N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             left_align,
  input  logic             auto_trig_en,
  input  logic [SRC_N-1:0] trig_flags,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             conv_start
);
  logic [RES_W-1:0] res_data;
  logic             res_locked;
  logic [SEL_W-1:0] trig_sel;
  logic             rd_lo;
  logic             rd_hi;

  adc_bus_regs #(.RES_W(RES_W)) i_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .left_align(left_align),
    .data(res_data), .rdata_q(bus_rdata), .trig_sel(trig_sel),
    .rd_lo(rd_lo), .rd_hi(rd_hi)
  );

  adc_result_hold #(.RES_W(RES_W)) i_hold (
    .clk(clk), .rst(rst), .conv_done(conv_done), .conv_result(conv_result),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .data_q(res_data), .locked_q(res_locked)
  );

  adc_trig_sel #(.SRC_N(SRC_N), .SEL_W(SEL_W)) i_trig (
    .clk(clk), .rst(rst), .enable(auto_trig_en), .sel(trig_sel),
    .flags(trig_flags), .start_q(conv_start)
  );
endmodule

// File: rtl/adc_fe_checker.sv
module adc_fe_checker
  import adc_fe_pkg::*;
#(
  parameter int unsigned RES_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       bus_addr,
  input logic             bus_rd,
  input logic [7:0]       bus_rdata,
  input logic             left_align,
  input logic             auto_trig_en,
  input logic             conv_start,
  input logic             res_locked,
  input logic [RES_W-1:0] res_data
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!conv_start && bus_rdata == 8'h00));

  // R2
  right_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_HI && !left_align) |=> (bus_rdata[7:RES_W-8] == '0));

  // R3
  left_lo_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_LO && left_align) |=> (bus_rdata[15-RES_W:0] == '0));

  // R4
  locked_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (res_locked && !(bus_rd && bus_addr == ADDR_HI)) |=> $stable(res_data));

  // R7
  ctrl_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_CTRL) |=> (bus_rdata[7] == 1'b0 && bus_rdata[5:3] == 3'b000));

  // R8
  start_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> $past(auto_trig_en));

  // R9
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
endmodule

bind adc_result_front adc_fe_checker #(.RES_W(RES_W)) i_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .left_align(left_align), .auto_trig_en(auto_trig_en),
  .conv_start(conv_start), .res_locked(res_locked), .res_data(res_data)
);

// File: tb/test_adc_result_front.sv
module test_adc_result_front;
  localparam int CLK_P = 10;
  localparam int RES_W = 10;
  localparam int SRC_N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic left_align = 1'b0, auto_trig_en = 1'b0;
  logic [SRC_N-1:0] trig_flags = '0;
  logic conv_done = 1'b0;
  logic [RES_W-1:0] conv_result = '0;
  logic conv_start;

  int checks = 0, errors = 0, starts = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_result_front #(.RES_W(RES_W), .SRC_N(SRC_N)) i_adc_result_front (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .left_align(left_align),
    .auto_trig_en(auto_trig_en), .trig_flags(trig_flags), .conv_done(conv_done),
    .conv_result(conv_result), .conv_start(conv_start)
  );

  always @(negedge clk) if (!rst && conv_start) starts++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic conv(input logic [RES_W-1:0] r);
    @(negedge clk); conv_result = r; conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  function automatic logic [7:0] exp_hi(logic [9:0] r, logic left);
    return left ? r[9:2] : {6'b0, r[9:8]};
  endfunction
  function automatic logic [7:0] exp_lo(logic [9:0] r, logic left);
    return left ? {r[1:0], 6'b0} : r[7:0];
  endfunction

  task automatic t_reset;
    logic [7:0] d;
    check("R1 start", conv_start, 0);
    rd(8'h78, d); check("R1 low", d, 0);
    rd(8'h79, d); check("R1 high", d, 0);
    rd(8'h7B, d); check("R1 ctrl", d, 0);
  endtask

  task automatic t_align(input logic left, input logic [9:0] r, string req);
    logic [7:0] d;
    left_align = left;
    conv(r);
    rd(8'h78, d); check({req, " low"}, d, exp_lo(r, left));
    rd(8'h79, d); check({req, " high"}, d, exp_hi(r, left));
  endtask

  task automatic t_lock;
    logic [7:0] d;
    left_align = 1'b0;
    conv(10'h123);
    rd(8'h78, d); check("R4 low", d, 8'h23);
    conv(10'h3FF);
    conv(10'h0C5);
    rd(8'h79, d); check("R4 high frozen", d, 8'h01);
    rd(8'h78, d); check("R5 latest pending low", d, 8'hC5);
    rd(8'h79, d); check("R5 latest pending high", d, 8'h00);
  endtask

  task automatic t_hi_only;
    logic [7:0] d;
    left_align = 1'b0;
    conv(10'h155);
    rd(8'h79, d); check("R6 high", d, 8'h01);
    conv(10'h2AA);
    rd(8'h79, d); check("R6 no lock", d, 8'h02);
    left_align = 1'b1;
    rd(8'h79, d); check("R6 8-bit left", d, 8'hAA);
    conv(10'h0FC);
    rd(8'h79, d); check("R6 8-bit left next", d, 8'h3F);
    left_align = 1'b0;
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    wr(8'h7B, 8'hFF);
    rd(8'h7B, d); check("R7 all ones", d, 8'h47);
    wr(8'h7B, 8'h38);
    rd(8'h7B, d); check("R7 reserved only", d, 8'h00);
    @(negedge clk); bus_addr = 8'h7B; bus_wdata = 8'h05; // no strobe
    @(negedge clk);
    rd(8'h7B, d); check("R7 no strobe", d, 8'h00);
  endtask

  task automatic t_disabled;
    int s0;
    wr(8'h7B, 8'h02);
    auto_trig_en = 1'b0;
    s0 = starts;
    @(negedge clk); trig_flags[2] = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 no start while disabled", starts - s0, 0);
    auto_trig_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 level at enable is no edge", starts - s0, 0);
    trig_flags = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_edge;
    int s0;
    auto_trig_en = 1'b1;
    wr(8'h7B, 8'h02);
    s0 = starts;
    @(negedge clk); trig_flags[2] = 1'b1;
    @(negedge clk); check("R9 pulse cycle", conv_start, 1);
    @(negedge clk); check("R9 pulse ends", conv_start, 0);
    repeat (4) @(negedge clk);
    check("R9 one pulse for held flag", starts - s0, 1);
    trig_flags[3] = 1'b1; // unselected source
    repeat (3) @(negedge clk);
    check("R9 other source ignored", starts - s0, 1);
    trig_flags = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_sel_change;
    int s0;
    auto_trig_en = 1'b1;
    wr(8'h7B, 8'h02);
    @(negedge clk); trig_flags[5] = 1'b1;
    repeat (2) @(negedge clk);
    s0 = starts;
    wr(8'h7B, 8'h05);
    repeat (3) @(negedge clk);
    check("R10 select to high flag", starts - s0, 1);
    wr(8'h7B, 8'h02);
    repeat (3) @(negedge clk);
    check("R10 select to low flag", starts - s0, 1);
    trig_flags = '0;
    auto_trig_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_align(1'b0, 10'h2A5, "R2");
    t_align(1'b1, 10'h2A5, "R3");
    t_align(1'b0, 10'h3FF, "R2");
    t_align(1'b1, 10'h001, "R3");
    t_lock();
    t_hi_only();
    t_ctrl();
    t_disabled();
    t_edge();
    t_sel_change();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule